// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Cache Controller

This block is a direct-mapped cache controller whose lines are split into two 32-byte sub-blocks, each filled, dirtied and written back on its own. The CPU presents a virtual index (the untranslated low address bits) together with the already translated physical tag. The block keeps tag, valid, dirty and data storage on chip, so a read hit returns data in the same cycle. Misses, evictions and write-through stores go out over a simple word-wide memory port with a request/acknowledge handshake.

A run-time mode input chooses between two write policies. In write-through mode every store goes to memory and a store miss allocates nothing. In copy-back mode a store hit stays local and a store miss first fills its sub-block. A second mode input, held constant between resets, selects a half-size arrangement with one sub-block per line. In that arrangement the sub-block select bit becomes the lowest line index bit. The number of lines is a parameter, and the field layout of the address is kept for any depth.

Top module: `cache_ctl`

## Requirements
- R1: A read whose sub-block is valid and whose stored line tag equals cpu_ptag raises cpu_ready in the same cycle as the request, returns the stored word on cpu_rdata, and issues no memory request.
- R2: A read miss keeps cpu_ready low while the addressed sub-block alone is filled. The fill is four memory reads in word order 0, 1, 2, 3. The other sub-block of the same line stays invalid. A memory request holds its address until it is acknowledged.
- R3: In full-size mode cpu_addr[L+5:6] selects the line (L = log2 of the line count), cpu_addr[5] the sub-block and cpu_addr[4:3] the 64-bit word. The memory word address is {tag, line, sub-block, word}.
- R4: In half-size mode cpu_addr[L+4:5] selects the line and only sub-block 0 exists. The memory word address is {1'b0, tag, line, word}, and an eviction writes back four words.
- R5: The physical tag takes part in the hit test: the same index with a different cpu_ptag is a miss.
- R6: With wb_mode = 0, every store causes exactly one memory write of cpu_wdata at the word address, and cpu_ready rises in the cycle that write is acknowledged. A store hit also updates the cached word. A store miss leaves the cache unchanged, so a following read of that address misses.
- R7: With wb_mode = 1, a store hit raises cpu_ready in the same cycle, causes no memory traffic, and leaves memory stale until the sub-block is evicted.
- R8: With wb_mode = 1, a store miss fills the addressed sub-block from memory, then merges the stored word; no memory write occurs.
- R9: When a miss displaces a line holding a different tag, every dirty sub-block of that line is written back (four words each) before the first fill read; clean sub-blocks are not written.
- R10: After reset all sub-blocks are invalid and clean, mem_req is low, and cpu_ready is low while there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 = copy-back with allocate, 0 = write-through without allocate |
| half_size | input | 1 | 1 = one sub-block per line; hold constant between resets |
| cpu_req | input | 1 | Request, held with its fields until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | log2(LINES)+3 | Virtual index bits [log2(LINES)+5:3] |
| cpu_ptag | input | TAG_W | Physical tag of the access |
| cpu_wdata | input | 64 | Store data |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | 64 | Load data, valid when cpu_ready is high |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | TAG_W+log2(LINES)+3 | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory accepts the word this cycle |
| mem_rdata | input | 64 | Memory read data, valid with mem_ack |

## Verification
A four-line configuration is swept over every line, sub-block and word for loads. The first word of each sub-block must miss and the rest must hit, which separates per-sub-block fill from whole-line fill and exposes any index or word field slip through the observed fill address. Stores are then applied as hits, as misses and against lines with zero, one or two dirty sub-blocks, in both policies. The memory read and write counts and their order distinguish write-through, copy-back, allocation and write-back-before-fill. A final sweep under a fresh tag must leave memory equal to the bench's model, and a half-size pass after reset repeats the load sweep and one eviction under the remapped index.

// File: rtl/cache_ctl.sv
module cache_ctl #(
  parameter int LINES = 256,
  parameter int TAG_W = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wb_mode,
  input  logic                          half_size,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [$clog2(LINES)+5:3]      cpu_addr,
  input  logic [TAG_W-1:0]              cpu_ptag,
  input  logic [63:0]                   cpu_wdata,
  output logic                          cpu_ready,
  output logic [63:0]                   cpu_rdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [TAG_W+$clog2(LINES)+2:0] mem_addr,
  output logic [63:0]                   mem_wdata,
  input  logic                          mem_ack,
  input  logic [63:0]                   mem_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int MA_W  = TAG_W + IDX_W + 3;

  typedef enum logic [1:0] {IDLE, FILL, EVICT, WTHRU} st_t;
  st_t st;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [2*LINES-1:0] val_q, dty_q;
  logic [63:0] dat_q [8*LINES];
  logic [1:0] beat;
  logic vic;

  wire [IDX_W-1:0] idx = half_size ? cpu_addr[IDX_W+4:5] : cpu_addr[IDX_W+5:6];
  wire             sb  = half_size ? 1'b0 : cpu_addr[5];
  wire [1:0]       wd  = cpu_addr[4:3];
  wire [IDX_W:0]   sel = {idx, sb};

  wire tag_eq     = tag_q[idx] == cpu_ptag;
  wire hit        = val_q[sel] && tag_eq;
  wire line_val   = val_q[{idx, 1'b0}] | val_q[{idx, 1'b1}];
  wire line_dirty = dty_q[{idx, 1'b0}] | dty_q[{idx, 1'b1}];
  wire new_line   = !(line_val && tag_eq);
  wire last       = beat == 2'd3;
  wire miss_go    = st == IDLE && cpu_req && !cpu_ready && !(cpu_we && !wb_mode);
  wire fill_start = miss_go && !(new_line && line_dirty);

  logic [TAG_W-1:0] a_tag;
  logic             a_sub;
  logic [1:0]       a_wd;
  logic             dwe;
  logic [IDX_W+2:0] dadr;
  logic [63:0]      ddat;

  assign mem_req   = st != IDLE;
  assign mem_we    = st == EVICT || st == WTHRU;
  assign cpu_rdata = dat_q[{idx, sb, wd}];
  assign cpu_ready = cpu_req && ((st == IDLE && hit && (!cpu_we || wb_mode)) ||
                                 (st == WTHRU && mem_ack));

  always_comb begin
    a_tag = cpu_ptag;
    a_sub = sb;
    a_wd  = beat;
    if (st == EVICT) begin
      a_tag = tag_q[idx];
      a_sub = vic;
    end else if (st == WTHRU) begin
      a_wd = wd;
    end
    mem_addr  = half_size ? {1'b0, a_tag, idx, a_wd} : {a_tag, idx, a_sub, a_wd};
    mem_wdata = (st == EVICT) ? dat_q[{idx, vic, beat}] : cpu_wdata;

    dwe  = 1'b0;
    dadr = {idx, sb, wd};
    ddat = cpu_wdata;
    if (st == IDLE && cpu_ready && cpu_we) dwe = 1'b1;
    if (st == WTHRU && mem_ack && hit) dwe = 1'b1;
    if (st == FILL && mem_ack) begin
      dwe  = 1'b1;
      dadr = {idx, sb, beat};
      ddat = mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (dwe) dat_q[dadr] <= ddat;
    if (fill_start && new_line) tag_q[idx] <= cpu_ptag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      beat  <= 2'd0;
      vic   <= 1'b0;
      val_q <= '0;
      dty_q <= '0;
    end else begin
      case (st)
        IDLE: begin
          if (cpu_ready && cpu_we) dty_q[sel] <= 1'b1;
          if (cpu_req && !cpu_ready) begin
            if (cpu_we && !wb_mode) st <= WTHRU;
            else if (new_line && line_dirty) begin
              st  <= EVICT;
              vic <= !dty_q[{idx, 1'b0}];
            end else begin
              st <= FILL;
              if (new_line) begin
                val_q[{idx, 1'b0}] <= 1'b0;
                val_q[{idx, 1'b1}] <= 1'b0;
              end
            end
          end
        end
        FILL: if (mem_ack) begin
          beat <= beat + 2'd1;
          if (last) begin
            val_q[sel] <= 1'b1;
            dty_q[sel] <= 1'b0;
            st         <= IDLE;
          end
        end
        EVICT: if (mem_ack) begin
          beat <= beat + 2'd1;
          if (last) begin
            dty_q[{idx, vic}] <= 1'b0;
            val_q[{idx, vic}] <= 1'b0;
            st                <= IDLE;
          end
        end
        default: if (mem_ack) st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_ctl_chk.sv
module cache_ctl_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          wb_mode,
  input logic          cpu_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr
);
  a_r1_read_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_we && cpu_ready |-> !mem_req);

  a_r6_wt_store_acked: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && !wb_mode && cpu_ready |-> mem_req && mem_we && mem_ack);

  a_r7_cb_store_local: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && wb_mode && cpu_ready |-> !mem_req);

  a_r2_mem_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r10_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);
endmodule

bind cache_ctl cache_ctl_chk #(.AW(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .wb_mode(wb_mode), .cpu_ready(cpu_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/sim_cache_ctl.sv
module sim_cache_ctl;
  localparam int LINES = 4;
  localparam int TAG_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, wb_mode = 1'b0, half_size = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:3] cpu_addr = '0;
  logic [3:0] cpu_ptag = '0;
  logic [63:0] cpu_wdata = '0;
  logic cpu_ready, mem_req, mem_we, mem_ack;
  logic [63:0] cpu_rdata, mem_wdata, mem_rdata;
  logic [8:0] mem_addr;

  cache_ctl #(.LINES(LINES), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .half_size(half_size),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ptag(cpu_ptag),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [63:0] mem [512];
  logic [63:0] gold [512];
  logic stall = 1'b0;
  int nrd = 0, nwr = 0;
  logic [8:0] rlog [1024];
  int wlog [1024];

  always @(posedge clk) stall <= ~stall;
  assign mem_ack   = mem_req & ~stall;
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk)
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        nwr <= nwr + 1;
      end else begin
        rlog[nrd % 1024] <= mem_addr;
        wlog[nrd % 1024] <= nwr;
        nrd <= nrd + 1;
      end
    end

  int vectors = 0, fails = 0;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic [8:0] pa(input logic [7:0] va, input logic [3:0] tg, input bit h);
    return h ? {1'b0, tg, va[6:3]} : {tg, va[7:3]};
  endfunction

  logic [63:0] rd;
  int cyc, dr, dw;
  logic [8:0] frd;
  bit wfirst;

  task automatic acc(input bit we, input logic [7:0] va, input logic [3:0] tg, input logic [63:0] wd);
    int r0, w0;
    @(negedge clk);
    r0 = nrd; w0 = nwr;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = va[7:3]; cpu_ptag = tg; cpu_wdata = wd;
    cyc = 0;
    #1;
    while (!cpu_ready && cyc < 300) begin
      @(negedge clk); #1; cyc++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
    dr = nrd - r0; dw = nwr - w0;
    frd = rlog[r0 % 1024];
    wfirst = (dr == 0) || (wlog[r0 % 1024] == nwr);
    if (cyc >= 300) chk(1'b0, "R2 access never completed", 64'(cyc), 64'd0);
    if (we) gold[pa(va, tg, half_size)] = wd;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!cpu_ready, "R10 ready low after reset", 64'(cpu_ready), 64'd0);
    chk(!mem_req, "R10 no memory request after reset", 64'(mem_req), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] va;
    logic [63:0] old;
    int bad;
    for (int a = 0; a < 512; a++) begin
      mem[a]  = {32'hC0DE0000 | 32'(a), 32'(a) * 32'h9E3779B1};
      gold[a] = mem[a];
    end
    do_reset();

    // full-size, write-through
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 4; w++) begin
          va = {2'(i), 1'(s), 2'(w), 3'b0};
          acc(1'b0, va, 4'd1, '0);
          chk(rd == gold[pa(va, 4'd1, 1'b0)], "R3 read data", rd, gold[pa(va, 4'd1, 1'b0)]);
          if (w == 0) begin
            chk(cyc > 0 && dr == 4 && dw == 0, "R2 miss fills one sub-block", 64'(dr), 64'd4);
            chk(frd == pa(va, 4'd1, 1'b0), "R3 fill word address", 64'(frd), 64'(pa(va, 4'd1, 1'b0)));
          end else
            chk(cyc == 0 && dr == 0 && dw == 0, "R1 hit same cycle", 64'(cyc), 64'd0);
        end

    for (int i = 0; i < 4; i++) begin
      va = {2'(i), 1'b0, 2'd1, 3'b0};
      acc(1'b1, va, 4'd1, 64'hAAAA_0000_0000_0000 | 64'(i));
      chk(dw == 1 && dr == 0, "R6 write-through single write", 64'(dw), 64'd1);
      chk(mem[pa(va, 4'd1, 1'b0)] == gold[pa(va, 4'd1, 1'b0)], "R6 memory updated",
          mem[pa(va, 4'd1, 1'b0)], gold[pa(va, 4'd1, 1'b0)]);
      acc(1'b0, va, 4'd1, '0);
      chk(cyc == 0 && rd == gold[pa(va, 4'd1, 1'b0)], "R6 hit updates cache",
          rd, gold[pa(va, 4'd1, 1'b0)]);
    end

    va = {2'd1, 1'b0, 2'd0, 3'b0};
    acc(1'b1, va, 4'd2, 64'hBEEF_0000_0000_0002);
    chk(dw == 1 && dr == 0, "R6 write miss goes to memory only", 64'(dr), 64'd0);
    chk(mem[pa(va, 4'd2, 1'b0)] == 64'hBEEF_0000_0000_0002, "R6 memory updated on miss",
        mem[pa(va, 4'd2, 1'b0)], 64'hBEEF_0000_0000_0002);
    acc(1'b0, va, 4'd2, '0);
    chk(cyc > 0 && dr == 4, "R6 no allocate on write miss", 64'(dr), 64'd4);
    chk(rd == 64'hBEEF_0000_0000_0002, "R6 read after write miss", rd, 64'hBEEF_0000_0000_0002);
    acc(1'b0, va, 4'd1, '0);
    chk(cyc > 0 && dr == 4 && dw == 0, "R5 other tag misses", 64'(dr), 64'd4);
    chk(rd == gold[pa(va, 4'd1, 1'b0)], "R5 data under old tag", rd, gold[pa(va, 4'd1, 1'b0)]);

    // full-size, copy-back
    @(negedge clk); wb_mode = 1'b1;
    va = {2'd0, 1'b0, 2'd2, 3'b0};
    old = mem[pa(va, 4'd1, 1'b0)];
    acc(1'b1, va, 4'd1, 64'h1111_2222_3333_4444);
    chk(cyc == 0 && dr == 0 && dw == 0, "R7 store hit local", 64'(dw), 64'd0);
    chk(mem[pa(va, 4'd1, 1'b0)] == old, "R7 memory stale", mem[pa(va, 4'd1, 1'b0)], old);
    acc(1'b0, va, 4'd1, '0);
    chk(cyc == 0 && rd == 64'h1111_2222_3333_4444, "R7 read back", rd, 64'h1111_2222_3333_4444);
    va = {2'd0, 1'b1, 2'd3, 3'b0};
    acc(1'b1, va, 4'd1, 64'h5555_6666_7777_8888);
    chk(cyc == 0 && dw == 0, "R7 second sub-block dirty", 64'(dw), 64'd0);

    va = {2'd0, 1'b0, 2'd0, 3'b0};
    acc(1'b0, va, 4'd3, '0);
    chk(dw == 8 && dr == 4 && wfirst, "R9 both dirty written before fill", 64'(dw), 64'd8);
    chk(mem[pa({2'd0, 1'b0, 2'd2, 3'b0}, 4'd1, 1'b0)] == 64'h1111_2222_3333_4444, "R9 sub0 written back",
        mem[pa({2'd0, 1'b0, 2'd2, 3'b0}, 4'd1, 1'b0)], 64'h1111_2222_3333_4444);
    chk(mem[pa({2'd0, 1'b1, 2'd3, 3'b0}, 4'd1, 1'b0)] == 64'h5555_6666_7777_8888, "R9 sub1 written back",
        mem[pa({2'd0, 1'b1, 2'd3, 3'b0}, 4'd1, 1'b0)], 64'h5555_6666_7777_8888);
    chk(rd == gold[pa(va, 4'd3, 1'b0)], "R9 data after eviction", rd, gold[pa(va, 4'd3, 1'b0)]);

    va = {2'd2, 1'b1, 2'd1, 3'b0};
    old = mem[pa(va, 4'd5, 1'b0)];
    acc(1'b1, va, 4'd5, 64'hC0C0_C0C0_0000_0005);
    chk(dr == 4 && dw == 0, "R8 store miss allocates", 64'(dr), 64'd4);
    chk(mem[pa(va, 4'd5, 1'b0)] == old, "R8 no memory write", mem[pa(va, 4'd5, 1'b0)], old);
    acc(1'b0, va, 4'd5, '0);
    chk(cyc == 0 && rd == 64'hC0C0_C0C0_0000_0005, "R8 merged word", rd, 64'hC0C0_C0C0_0000_0005);
    acc(1'b0, {2'd2, 1'b0, 2'd0, 3'b0}, 4'd6, '0);
    chk(dw == 4 && dr == 4 && wfirst, "R9 only dirty sub-block written", 64'(dw), 64'd4);
    chk(mem[pa(va, 4'd5, 1'b0)] == 64'hC0C0_C0C0_0000_0005, "R9 written-back data",
        mem[pa(va, 4'd5, 1'b0)], 64'hC0C0_C0C0_0000_0005);

    acc(1'b1, {2'd3, 1'b1, 2'd0, 3'b0}, 4'd1, 64'hD00D_0000_0000_0003);
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 4; w++) begin
          va = {2'(i), 1'(s), 2'(w), 3'b0};
          acc(1'b0, va, 4'd7, '0);
          chk(rd == gold[pa(va, 4'd7, 1'b0)], "R3 sweep under new tag", rd, gold[pa(va, 4'd7, 1'b0)]);
        end
    bad = 0;
    for (int a = 0; a < 512; a++) if (mem[a] != gold[a]) bad++;
    chk(bad == 0, "R9 memory matches model", 64'(bad), 64'd0);

    // half-size, copy-back
    @(negedge clk); half_size = 1'b1;
    do_reset();
    for (int i = 0; i < 4; i++)
      for (int w = 0; w < 4; w++) begin
        va = {1'b0, 2'(i), 2'(w), 3'b0};
        acc(1'b0, va, 4'd1, '0);
        chk(rd == gold[pa(va, 4'd1, 1'b1)], "R4 read data", rd, gold[pa(va, 4'd1, 1'b1)]);
        if (w == 0) begin
          chk(cyc > 0 && dr == 4, "R4 miss fills", 64'(dr), 64'd4);
          chk(frd == pa(va, 4'd1, 1'b1), "R4 fill word address", 64'(frd), 64'(pa(va, 4'd1, 1'b1)));
        end else
          chk(cyc == 0 && dr == 0, "R1 half-size hit", 64'(cyc), 64'd0);
      end
    va = {1'b0, 2'd3, 2'd2, 3'b0};
    acc(1'b1, va, 4'd1, 64'hE0E0_0000_0000_0001);
    chk(cyc == 0 && dw == 0, "R7 half-size store hit", 64'(dw), 64'd0);
    acc(1'b0, {1'b0, 2'd3, 2'd0, 3'b0}, 4'd2, '0);
    chk(dw == 4 && dr == 4 && wfirst, "R4 single sub-block eviction", 64'(dw), 64'd4);
    chk(mem[pa(va, 4'd1, 1'b1)] == 64'hE0E0_0000_0000_0001, "R4 written-back address",
        mem[pa(va, 4'd1, 1'b1)], 64'hE0E0_0000_0000_0001);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule